// File: doc/BRIEF.md
# Dual Bidirectional Port with Edge-Captured Inputs

This block gives a processor two general-purpose parallel ports, A and B, each `W` lines wide. Every line can be an output or an input, chosen bit by bit in a direction register. Output lines drive the value held in the port's output register. For input lines, software can read either the live pin state or a snapshot. The snapshot is taken when the port's control input makes a transition of a chosen polarity.

Each control input passes through a synchronizer chain before edge detection, so it may be fully asynchronous. Port A data can be reached at two addresses. The primary address re-arms the snapshot when read; the quiet alias does not. A snapshot, once taken, is frozen until software re-arms it through the primary data address of that port. This lets software see exactly the pins at the moment of the strobe, even if the pins move afterwards.

Top module: `via_port_pair`

## Requirements
- R1: After reset every line is an input (both output-enable buses 0). Both output registers, both direction registers and all capture control bits read 0.
- R2: A write to address 1 or address 15 loads the port A output register, which appears on `pa_out` from the next cycle. A write to address 0 does the same for port B on `pb_out`.
- R3: Address 3 is the port A direction register and address 2 the port B direction register. A bit value of 1 makes that line an output, and the output enable follows from the next cycle. Both registers read back as written.
- R4: A read of a port's data address returns the output register bit on output lines. On input lines it returns the live pin when capture is disabled for that port.
- R5: Capture control is at address 11: bit 0 enables port A capture and bit 1 enables port B capture. Edge select is at address 12: bit 0 applies to port A and bit 4 to port B, where 0 selects the falling edge and 1 the rising edge. These four bits read back in place, and all other bits of both registers read 0.
- R6: With capture enabled, an active edge on the port's control input loads the port's pins into its snapshot. The load happens on the third rising clock edge after the input changes. Input lines then read the snapshot, and before any load the snapshot is 0.
- R7: After a load, further active edges are ignored until the port's data is read at address 1 (port A) or address 0 (port B). A read at address 15 does not re-arm.
- R8: A transition of the non-selected polarity never loads the snapshot.
- R9: Clearing a port's capture enable makes its input lines read the live pins again.
- R10: Addresses 4 to 10, 13 and 14 read 0, and writes to them change no output, direction or control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data (combinational from address) |
| pa_in | input | W | Port A pin input values |
| pa_out | output | W | Port A pin output values |
| pa_oe | output | W | Port A output enables |
| ca_ctl | input | 1 | Port A capture strobe (asynchronous) |
| pb_in | input | W | Port B pin input values |
| pb_out | output | W | Port B pin output values |
| pb_oe | output | W | Port B output enables |
| cb_ctl | input | 1 | Port B capture strobe (asynchronous) |

## Verification
The read merge is swept over direction masks that include all-in, all-out, nibble splits and alternating patterns. These run against several output and pin values, so a swapped or inverted mask term shows up on one side of the split. The capture path is driven by strobes of both polarities, with the pins changed between strobes. This separates a snapshot from a live read, an armed snapshot from a frozen one, and re-arming by the primary address from re-arming by the quiet alias. A pass through the unmapped addresses shows whether decode leaks into the real registers.

// File: rtl/via_pp_pkg.sv
package via_pp_pkg;
   localparam int NUM_PORTS = 2;
   localparam int PORT_A    = 0;
   localparam int PORT_B    = 1;

   // Register addresses (decoded by software, so kept fixed)
   localparam logic [3:0] REG_DATA_B       = 4'd0;
   localparam logic [3:0] REG_DATA_A       = 4'd1;
   localparam logic [3:0] REG_DIR_B        = 4'd2;
   localparam logic [3:0] REG_DIR_A        = 4'd3;
   localparam logic [3:0] REG_CAPTURE_CTL  = 4'd11;
   localparam logic [3:0] REG_EDGE_CTL     = 4'd12;
   localparam logic [3:0] REG_DATA_A_QUIET = 4'd15;

   // Bit positions inside the control registers
   localparam int CAP_A_BIT  = 0;
   localparam int CAP_B_BIT  = 1;
   localparam int EDGE_A_BIT = 0;
   localparam int EDGE_B_BIT = 4;
endpackage

// File: rtl/via_pp_edge_sync.sv
module via_pp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic rise_sel,
   output logic active_edge
);
   if (STAGES < 2) begin : g_bad_stages
      $error("via_pp_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              synced;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign synced = chain_q[STAGES-1];

   always_comb begin
      if (rise_sel) active_edge = synced & ~prev_q;
      else          active_edge = ~synced & prev_q;
   end
endmodule

// File: rtl/via_pp_port.sv
module via_pp_port #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   input  logic         cap_en,
   input  logic         rise_sel,
   input  logic         ctl_in,
   input  logic         release_rd,
   input  logic [W-1:0] pins,
   output logic [W-1:0] data_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] rd_val
);
   if (W < 1) begin : g_bad_width
      $error("via_pp_port: W must be positive");
   end

   logic         hit;
   logic [W-1:0] snap_q;
   logic         armed_q;
   logic [W-1:0] in_view;

   via_pp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .async_in    (ctl_in),
      .rise_sel    (rise_sel),
      .active_edge (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else begin
         if (data_we) data_q <= wdata;
         if (dir_we)  dir_q  <= wdata;
      end
   end

   // Snapshot: one load per arming, re-armed by primary data read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q  <= '0;
         armed_q <= 1'b1;
      end else if (!cap_en) begin
         armed_q <= 1'b1;
      end else if (hit && armed_q) begin
         snap_q  <= pins;
         armed_q <= 1'b0;
      end else if (release_rd) begin
         armed_q <= 1'b1;
      end
   end

   assign in_view = cap_en ? snap_q : pins;

   for (genvar b = 0; b < W; b++) begin : g_merge
      assign rd_val[b] = dir_q[b] ? data_q[b] : in_view[b];
   end
endmodule

// File: rtl/via_port_pair.sv
module via_port_pair
   import via_pp_pkg::*;
#(
   parameter int W           = 8,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   output logic [W-1:0]  bus_rdata,
   input  logic [W-1:0]  pa_in,
   output logic [W-1:0]  pa_out,
   output logic [W-1:0]  pa_oe,
   input  logic          ca_ctl,
   input  logic [W-1:0]  pb_in,
   output logic [W-1:0]  pb_out,
   output logic [W-1:0]  pb_oe,
   input  logic          cb_ctl
);
   if (W < EDGE_B_BIT + 1) begin : g_bad_w
      $error("via_port_pair: W must hold the edge select bits");
   end
   if (AW < 4) begin : g_bad_aw
      $error("via_port_pair: AW must be at least 4");
   end

   localparam logic [AW-1:0] A_DATA_B  = AW'(REG_DATA_B);
   localparam logic [AW-1:0] A_DATA_A  = AW'(REG_DATA_A);
   localparam logic [AW-1:0] A_DIR_B   = AW'(REG_DIR_B);
   localparam logic [AW-1:0] A_DIR_A   = AW'(REG_DIR_A);
   localparam logic [AW-1:0] A_CAP     = AW'(REG_CAPTURE_CTL);
   localparam logic [AW-1:0] A_EDGE    = AW'(REG_EDGE_CTL);
   localparam logic [AW-1:0] A_QUIET   = AW'(REG_DATA_A_QUIET);

   logic wr_stb, rd_stb;
   assign wr_stb = bus_sel &  bus_wr;
   assign rd_stb = bus_sel & ~bus_wr;

   logic [NUM_PORTS-1:0] cap_en_q;
   logic [NUM_PORTS-1:0] rise_q;
   logic [NUM_PORTS-1:0] ctl_raw;
   logic [NUM_PORTS-1:0][W-1:0] pins, data_q, dir_q, rd_val;

   assign pins[PORT_A]    = pa_in;
   assign pins[PORT_B]    = pb_in;
   assign ctl_raw[PORT_A] = ca_ctl;
   assign ctl_raw[PORT_B] = cb_ctl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_en_q <= '0;
         rise_q   <= '0;
      end else if (wr_stb) begin
         if (bus_addr == A_CAP) begin
            cap_en_q[PORT_A] <= bus_wdata[CAP_A_BIT];
            cap_en_q[PORT_B] <= bus_wdata[CAP_B_BIT];
         end
         if (bus_addr == A_EDGE) begin
            rise_q[PORT_A] <= bus_wdata[EDGE_A_BIT];
            rise_q[PORT_B] <= bus_wdata[EDGE_B_BIT];
         end
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [AW-1:0] DATA_ADDR = (p == PORT_A) ? A_DATA_A : A_DATA_B;
      localparam logic [AW-1:0] DIR_ADDR  = (p == PORT_A) ? A_DIR_A  : A_DIR_B;
      localparam bit HAS_ALIAS = (p == PORT_A);

      logic data_we, dir_we, rel;
      assign data_we = wr_stb && ((bus_addr == DATA_ADDR) ||
                                  (HAS_ALIAS && (bus_addr == A_QUIET)));
      assign dir_we  = wr_stb && (bus_addr == DIR_ADDR);
      assign rel     = rd_stb && (bus_addr == DATA_ADDR);

      via_pp_port #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .data_we    (data_we),
         .dir_we     (dir_we),
         .wdata      (bus_wdata),
         .cap_en     (cap_en_q[p]),
         .rise_sel   (rise_q[p]),
         .ctl_in     (ctl_raw[p]),
         .release_rd (rel),
         .pins       (pins[p]),
         .data_q     (data_q[p]),
         .dir_q      (dir_q[p]),
         .rd_val     (rd_val[p])
      );
   end

   assign pa_out = data_q[PORT_A];
   assign pa_oe  = dir_q[PORT_A];
   assign pb_out = data_q[PORT_B];
   assign pb_oe  = dir_q[PORT_B];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_DATA_B:         bus_rdata = rd_val[PORT_B];
         A_DATA_A, A_QUIET: bus_rdata = rd_val[PORT_A];
         A_DIR_B:          bus_rdata = dir_q[PORT_B];
         A_DIR_A:          bus_rdata = dir_q[PORT_A];
         A_CAP: begin
            bus_rdata[CAP_A_BIT] = cap_en_q[PORT_A];
            bus_rdata[CAP_B_BIT] = cap_en_q[PORT_B];
         end
         A_EDGE: begin
            bus_rdata[EDGE_A_BIT] = rise_q[PORT_A];
            bus_rdata[EDGE_B_BIT] = rise_q[PORT_B];
         end
         default:          bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/via_port_pair_chk.sv
module via_port_pair_chk #(
   parameter int W  = 8,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [W-1:0]  bus_wdata,
   input logic [W-1:0]  bus_rdata,
   input logic [W-1:0]  pa_out,
   input logic [W-1:0]  pa_oe,
   input logic [W-1:0]  pb_out,
   input logic [W-1:0]  pb_oe
);
   logic wr_a_data, wr_b_data, wr_a_dir, wr_b_dir;
   assign wr_a_data = bus_sel && bus_wr &&
                      (bus_addr == AW'(1) || bus_addr == AW'(15));
   assign wr_b_data = bus_sel && bus_wr && (bus_addr == AW'(0));
   assign wr_a_dir  = bus_sel && bus_wr && (bus_addr == AW'(3));
   assign wr_b_dir  = bus_sel && bus_wr && (bus_addr == AW'(2));

   // R2
   a_data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a_data |=> (pa_out == $past(bus_wdata)));

   // R2
   a_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a_data |=> $stable(pa_out));

   // R2
   b_data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_b_data |=> (pb_out == $past(bus_wdata)));

   // R3
   a_dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a_dir |=> (pa_oe == $past(bus_wdata)));

   // R3
   b_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_b_dir |=> $stable(pb_oe));

   // R3
   dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == AW'(2)) |-> (bus_rdata == pb_oe));
endmodule

bind via_port_pair via_port_pair_chk #(.W(W), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pa_out    (pa_out),
   .pa_oe     (pa_oe),
   .pb_out    (pb_out),
   .pb_oe     (pb_oe)
);

// File: tb/tb_via_port_pair.sv
`timescale 1ns/1ps
module tb_via_port_pair;
   localparam int W  = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [W-1:0]  pa_in = '0, pb_in = '0;
   logic [W-1:0]  pa_out, pa_oe, pb_out, pb_oe;
   logic          ca_ctl = 1'b0, cb_ctl = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   via_port_pair #(.W(W), .AW(AW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .ca_ctl(ca_ctl),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .cb_ctl(cb_ctl)
   );

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic reg_rd(input int a, output logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic set_ca(input logic v);
      @(negedge clk); ca_ctl = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_cb(input logic v);
      @(negedge clk); cb_ctl = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual 00 expected 01");
         report();
      end
   end

   initial begin
      logic [W-1:0] r;
      logic [W-1:0] dirs [6];
      logic [W-1:0] vals [4];
      dirs = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h3C, 8'h81};
      vals = '{8'h00, 8'hFF, 8'h96, 8'h5B};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pa_oe", pa_oe, 8'h00);
      check("R1 pb_oe", pb_oe, 8'h00);
      check("R1 pa_out", pa_out, 8'h00);
      check("R1 pb_out", pb_out, 8'h00);
      reg_rd(2, r);  check("R1 dir B", r, 8'h00);
      reg_rd(3, r);  check("R1 dir A", r, 8'h00);
      reg_rd(11, r); check("R1 capture ctl", r, 8'h00);
      reg_rd(12, r); check("R1 edge ctl", r, 8'h00);

      // R2 both data addresses of port A, and port B
      reg_wr(1, 8'h3E);  @(negedge clk); check("R2 pa_out via 1", pa_out, 8'h3E);
      reg_wr(15, 8'hC1); @(negedge clk); check("R2 pa_out via 15", pa_out, 8'hC1);
      reg_wr(0, 8'h7D);  @(negedge clk); check("R2 pb_out via 0", pb_out, 8'h7D);

      // R3 / R4 sweep: direction masks x data x pins
      foreach (dirs[i]) begin
         reg_wr(3, dirs[i]);
         reg_wr(2, ~dirs[i]);
         @(negedge clk);
         check("R3 pa_oe", pa_oe, dirs[i]);
         check("R3 pb_oe", pb_oe, ~dirs[i]);
         reg_rd(3, r); check("R3 dir A readback", r, dirs[i]);
         foreach (vals[j]) begin
            reg_wr(1, vals[j]);
            reg_wr(0, ~vals[j]);
            pa_in = vals[(j + 1) % 4] ^ 8'h24;
            pb_in = vals[(j + 2) % 4] ^ 8'h42;
            reg_rd(1, r);
            check("R4 port A merge", r,
                  (vals[j] & dirs[i]) | (pa_in & ~dirs[i]));
            reg_rd(0, r);
            check("R4 port B merge", r,
                  (~vals[j] & ~dirs[i]) | (pb_in & dirs[i]));
         end
      end

      // R5 control register fields
      reg_wr(11, 8'hFF); reg_rd(11, r); check("R5 capture ctl bits", r, 8'h03);
      reg_wr(12, 8'hFF); reg_rd(12, r); check("R5 edge ctl bits", r, 8'h11);
      reg_wr(12, 8'h10); reg_rd(12, r); check("R5 edge ctl B only", r, 8'h10);
      reg_wr(11, 8'h00); reg_wr(12, 8'h00);

      // Port A capture on falling edge
      reg_wr(3, 8'h00);
      reg_wr(11, 8'h01);
      pa_in = 8'h5A;
      set_ca(1'b1);               // rising: inactive for A
      reg_rd(15, r); check("R8 rising edge ignored on A", r, 8'h00);
      set_ca(1'b0);               // falling: loads 5A
      pa_in = 8'hC3;
      reg_rd(15, r); check("R6 A snapshot after falling edge", r, 8'h5A);
      set_ca(1'b1); set_ca(1'b0); // frozen, not re-armed
      reg_rd(15, r); check("R7 quiet alias read keeps freeze", r, 8'h5A);
      set_ca(1'b1); set_ca(1'b0);
      reg_rd(15, r); check("R7 still frozen", r, 8'h5A);
      reg_rd(1, r);  check("R7 primary read value", r, 8'h5A);
      set_ca(1'b1); set_ca(1'b0); // re-armed: loads C3
      reg_rd(15, r); check("R7 re-armed load", r, 8'hC3);
      reg_wr(3, 8'hF0);
      reg_wr(1, 8'h69);
      reg_rd(1, r);  check("R6 mixed dir with snapshot", r, 8'h63);
      pa_in = 8'h3C;
      reg_rd(1, r);  check("R6 pins change ignored", r, 8'h63);
      reg_wr(11, 8'h00);
      reg_rd(1, r);  check("R9 live pins after disable", r, 8'h6C);

      // Port B capture on rising edge
      reg_wr(2, 8'h00);
      reg_wr(12, 8'h10);
      reg_wr(11, 8'h02);
      pb_in = 8'h77;
      set_cb(1'b1);
      pb_in = 8'h11;
      reg_rd(0, r);  check("R6 B snapshot after rising edge", r, 8'h77);
      set_cb(1'b0);
      reg_rd(0, r);  check("R8 falling edge ignored on B", r, 8'h77);
      set_cb(1'b1);
      reg_rd(0, r);  check("R7 B re-armed by address 0", r, 8'h11);
      reg_wr(11, 8'h00);
      pb_in = 8'hE4;
      reg_rd(0, r);  check("R9 B live pins", r, 8'hE4);

      // R10 unmapped addresses
      for (int a = 4; a <= 14; a++) begin
         if (a == 11 || a == 12) continue;
         reg_wr(a, 8'hFF);
         reg_rd(a, r); check("R10 unmapped reads zero", r, 8'h00);
      end
      @(negedge clk);
      check("R10 pa_out untouched", pa_out, 8'h69);
      check("R10 pa_oe untouched", pa_oe, 8'hF0);
      check("R10 pb_oe untouched", pb_oe, 8'h00);
      reg_rd(11, r); check("R10 capture ctl untouched", r, 8'h00);
      reg_rd(12, r); check("R10 edge ctl untouched", r, 8'h10);

      done = 1'b1;
      report();
   end
endmodule